// File: doc/BRIEF.md
# Cache Tag Memory with Address Comparator

This block is the tag store of a direct-mapped secondary cache. One entry address selects a line in two arrays that are enabled separately: a tag array that holds the upper address bits of the cached line, and a three-bit status array. Writes to either array are clocked. Reads and the tag compare are combinational, so a new address or probe tag reaches the outputs in the same cycle without waiting for a clock edge.

When neither the tag write enable nor the tag output enable is asserted, the block is in compare mode. The value on the tag input is then treated as the probe tag and compared with the stored tag at the current entry, which produces a hit output. A static mode input decides how the status bits are used. In dedicated mode, bit 0 is a valid flag that gates the hit, and the other two bits are stored but have no effect on the hit. In generic mode, all three bits are plain storage.

A synchronous reset clears the whole status array in one cycle, so every lookup misses until lines are refilled. Two chip selects of opposite polarity let two blocks be cascaded in depth. Each bidirectional bus is modelled as a data output plus a drive-enable output.

Top module: `tagram_cmp`

## Requirements
- R1: The block is selected only when `cs_n` is 0 and `cs` is 1. Any other combination of the two deselects it.
- R2: When the block is selected and `we_tag_n` is 0 at a rising clock edge, `tag_i` is stored at entry `addr`. Only that entry changes.
- R3: `tag_oe` is 1 exactly when the block is selected and `oe_tag_n` is 0. While `tag_oe` is 1, `tag_o` shows the stored tag of the current `addr` in the same cycle.
- R4: `match_o` can be 1 only when the block is selected and both `we_tag_n` and `oe_tag_n` are 1 (compare mode). It follows `addr` and `tag_i` combinationally.
- R5: The status array has its own controls. When the block is selected and `we_stat_n` is 0 at an edge, `stat_i` is stored. `stat_oe` is 1 when the block is selected and `oe_stat_n` is 0, and `stat_o` then shows the stored status. The bit layout is bit 0 valid, bit 1 dirty, bit 2 write-through. A status write leaves the tag array unchanged, and a tag write leaves the status array unchanged.
- R6: When `rst` is 1 at a rising edge, every status entry becomes 0 on that edge. A status write in the same cycle is lost.
- R7: While the block is deselected, all write requests are ignored, and `tag_oe`, `stat_oe`, `match_oe` and `match_o` are all 0. `match_oe` is 1 whenever the block is selected.
- R8: In dedicated mode (`generic_mode` = 0), `match_o` is 1 only if the stored tag equals `tag_i` and the stored valid bit (status bit 0) is 1. After a reset, every lookup in this mode misses.
- R9: In generic mode (`generic_mode` = 1), `match_o` is 1 exactly when the stored tag equals `tag_i`, whatever the status bits hold. The dirty bit never affects `match_o` in either mode.
- R10: Reset does not alter the tag array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high clear of the status array |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| generic_mode | input | 1 | Static: 0 selects dedicated status bits, 1 selects generic status bits |
| addr | input | ADDR_W | Entry address shared by both arrays |
| we_tag_n | input | 1 | Active-low tag write enable |
| oe_tag_n | input | 1 | Active-low tag output enable |
| tag_i | input | TAG_W | Tag write data, or the probe tag in compare mode |
| tag_o | output | TAG_W | Tag read data |
| tag_oe | output | 1 | Drive enable for the tag bus |
| we_stat_n | input | 1 | Active-low status write enable |
| oe_stat_n | input | 1 | Active-low status output enable |
| stat_i | input | 3 | Status write data (bit 0 valid, bit 1 dirty, bit 2 write-through) |
| stat_o | output | 3 | Status read data |
| stat_oe | output | 1 | Drive enable for the status bus |
| match_o | output | 1 | Hit indication in compare mode |
| match_oe | output | 1 | Drive enable for the hit output |

## Verification
The assertions check the following on every cycle: a hit is never reported outside compare mode, a hit in dedicated mode always comes with a set valid bit, a hit always comes with equal tags, a deselected block keeps every enable low, and a write or reset has landed at the edge where it took effect. Other behaviour needs the bench's scenarios. A probe with a stored tag and its valid bit set must actually hit, and a probe in generic mode must hit on entries whose valid bit is clear. The bench also checks that a write attempted while deselected leaves no trace, and that a reset leaves every tag in place. It sweeps every entry of a small configuration in both modes, using addresses built from CPU address fields.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    typedef struct packed {
        logic wt;
        logic dirty;
        logic valid;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef enum logic {
        MODE_DEDICATED = 1'b0,
        MODE_GENERIC   = 1'b1
    } stat_mode_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_READ,
        OP_COMPARE
    } tag_op_e;

    function automatic tag_op_e decode_tag_op(input logic sel, input logic we_n, input logic oe_n);
        if (!sel)       return OP_NONE;
        else if (!we_n) return OP_WRITE;
        else if (!oe_n) return OP_READ;
        else            return OP_COMPARE;
    endfunction

endpackage

// File: rtl/tagram_tag_array.sv
module tagram_tag_array #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [TAG_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

    AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && addr == $past(addr)) |-> rdata == $past(wdata)); // R2

endmodule

// File: rtl/tagram_stat_array.sv
module tagram_stat_array
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  stat_t             wdata,
    output stat_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    stat_t ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                                ent[g] <= '0;
            else if (wr_en && addr == ADDR_W'(g))   ent[g] <= wdata;
        end
    end

    assign rdata = ent[addr];

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rdata == '0); // R6

    AST_STAT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && addr == $past(addr)) |-> rdata == $past(wdata)); // R5

endmodule

// File: rtl/tagram_match.sv
module tagram_match
    import tagram_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             cmp_en,
    input  stat_mode_e       mode,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  logic             stored_valid,
    output logic             hit
);
    logic tag_eq;
    logic qualify;

    assign tag_eq  = (stored_tag == probe_tag);
    assign qualify = (mode == MODE_GENERIC) || stored_valid;
    assign hit     = cmp_en && tag_eq && qualify;

endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              generic_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_tag_n,
    input  logic              oe_tag_n,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic              tag_oe,
    input  logic              we_stat_n,
    input  logic              oe_stat_n,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              stat_oe,
    output logic              match_o,
    output logic              match_oe
);
    logic             sel;
    tag_op_e          op;
    logic             tag_wr;
    logic             stat_wr;
    logic [TAG_W-1:0] tag_rd;
    stat_t            stat_rd;

    assign sel     = !cs_n && cs;
    assign op      = decode_tag_op(sel, we_tag_n, oe_tag_n);
    assign tag_wr  = (op == OP_WRITE);
    assign stat_wr = sel && !we_stat_n;

    tagram_tag_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tag (
        .clk   (clk),
        .rst   (rst),
        .wr_en (tag_wr),
        .addr  (addr),
        .wdata (tag_i),
        .rdata (tag_rd)
    );

    tagram_stat_array #(.ADDR_W(ADDR_W)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .wr_en (stat_wr),
        .addr  (addr),
        .wdata (stat_t'(stat_i)),
        .rdata (stat_rd)
    );

    tagram_match #(.TAG_W(TAG_W)) u_match (
        .cmp_en       (op == OP_COMPARE),
        .mode         (stat_mode_e'(generic_mode)),
        .stored_tag   (tag_rd),
        .probe_tag    (tag_i),
        .stored_valid (stat_rd.valid),
        .hit          (match_o)
    );

    assign tag_oe   = sel && !oe_tag_n;
    assign tag_o    = tag_oe ? tag_rd : '0;
    assign stat_oe  = sel && !oe_stat_n;
    assign stat_o   = stat_oe ? stat_rd : '0;
    assign match_oe = sel;

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !cs) |-> (!tag_oe && !stat_oe && !match_oe && !match_o)); // R7

    AST_MATCH_ONLY_COMPARE: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (we_tag_n && oe_tag_n && !cs_n && cs)); // R4

    AST_DEDICATED_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (match_o && !generic_mode) |-> stat_rd.valid); // R8

    AST_HIT_MEANS_EQUAL: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (tag_rd == tag_i)); // R9

endmodule

// File: tb/sim_tagram_cmp.sv
module sim_tagram_cmp;
    localparam int AW    = 6;
    localparam int TW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs_n, cs, generic_mode;
    logic [AW-1:0] addr;
    logic          we_tag_n, oe_tag_n, we_stat_n, oe_stat_n;
    logic [TW-1:0] tag_i, tag_o;
    logic [2:0]    stat_i, stat_o;
    logic          tag_oe, stat_oe, match_o, match_oe;

    logic [TW-1:0] m_tag  [DEPTH];
    logic [2:0]    m_stat [DEPTH];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    tagram_cmp #(.ADDR_W(AW), .TAG_W(TW)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cs(cs), .generic_mode(generic_mode),
        .addr(addr), .we_tag_n(we_tag_n), .oe_tag_n(oe_tag_n), .tag_i(tag_i),
        .tag_o(tag_o), .tag_oe(tag_oe), .we_stat_n(we_stat_n), .oe_stat_n(oe_stat_n),
        .stat_i(stat_i), .stat_o(stat_o), .stat_oe(stat_oe),
        .match_o(match_o), .match_oe(match_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CPU address: tag field in bits 30:19, entry index starting at bit 5 (32-byte lines)
    function automatic logic [31:0] cpu_addr(input int idx, input int salt);
        logic [11:0] t;
        t = 12'((idx * 37 + salt * 11 + 5) & 12'hFFF);
        return (32'(t) << 19) | (32'(idx) << 5);
    endfunction

    function automatic logic [2:0] stat_pat(input int idx);
        logic [2:0] s;
        s[0] = (idx % 3) != 0;
        s[1] = idx[1];
        s[2] = idx[2];
        return s;
    endfunction

    task automatic idle();
        cs_n = 1'b0; cs = 1'b1;
        we_tag_n = 1'b1; oe_tag_n = 1'b1; we_stat_n = 1'b1; oe_stat_n = 1'b1;
    endtask

    task automatic wr_tag(input logic [31:0] ca);
        @(negedge clk);
        idle();
        addr = ca[5+AW-1:5]; tag_i = ca[30:19]; we_tag_n = 1'b0;
        @(posedge clk);
        m_tag[ca[5+AW-1:5]] = ca[30:19];
    endtask

    task automatic wr_stat(input int a, input logic [2:0] s);
        @(negedge clk);
        idle();
        addr = AW'(a); stat_i = s; we_stat_n = 1'b0;
        @(posedge clk);
        m_stat[a] = s;
    endtask

    task automatic read_chk(input int a, input string rq_tag, input string rq_stat);
        @(negedge clk);
        idle();
        addr = AW'(a); oe_tag_n = 1'b0; oe_stat_n = 1'b0;
        #1;
        chk(tag_oe === 1'b1, "R3 tag_oe", 32'(tag_oe), 1);
        chk(tag_o === m_tag[a], rq_tag, 32'(tag_o), 32'(m_tag[a]));
        chk(stat_o === m_stat[a], rq_stat, 32'(stat_o), 32'(m_stat[a]));
        chk(match_o === 1'b0, "R4 no match in read", 32'(match_o), 0);
    endtask

    task automatic cmp_chk(input int a, input logic [TW-1:0] probe, input logic gm, input string rq);
        logic exp;
        @(negedge clk);
        idle();
        generic_mode = gm; addr = AW'(a); tag_i = probe;
        #1;
        exp = (m_tag[a] == probe) && (gm || m_stat[a][0]);
        chk(match_o === exp, rq, 32'(match_o), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; generic_mode = 1'b0; addr = '0; tag_i = '0; stat_i = '0;
        idle();
        for (int i = 0; i < DEPTH; i++) m_stat[i] = '0;
        // status write during reset is lost (R6)
        @(negedge clk); addr = 5; stat_i = 3'b111; we_stat_n = 1'b0;
        @(posedge clk); @(negedge clk); rst = 1'b0; idle();

        // R6: reset state, every status entry cleared; R8: every lookup misses
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk); idle(); addr = AW'(i); oe_stat_n = 1'b0;
            #1;
            chk(stat_o === 3'b000, "R6 status cleared", 32'(stat_o), 0);
            oe_stat_n = 1'b1; tag_i = 12'(i); #1;
            chk(match_o === 1'b0, "R8 reset miss", 32'(match_o), 0);
            chk(match_oe === 1'b1, "R7 match_oe when selected", 32'(match_oe), 1);
        end

        // fill tags from CPU addresses, then status
        for (int i = 0; i < DEPTH; i++) wr_tag(cpu_addr(i, 0));
        for (int i = 0; i < DEPTH; i++) wr_stat(i, stat_pat(i));

        // R2/R3/R5: readback of both arrays (status writes left tags intact)
        for (int i = 0; i < DEPTH; i++) read_chk(i, "R2 R5 tag after status writes", "R5 status readback");

        // R8 dedicated mode and R9 generic mode sweeps with hit and miss probes
        for (int i = 0; i < DEPTH; i++) begin
            cmp_chk(i, m_tag[i], 1'b0, "R8 dedicated probe");
            cmp_chk(i, m_tag[i] ^ 12'h801, 1'b0, "R8 dedicated miss");
            cmp_chk(i, m_tag[i], 1'b1, "R9 generic probe");
            cmp_chk(i, m_tag[i] ^ 12'h040, 1'b1, "R9 generic miss");
        end

        // R9: dirty bit never gates the hit
        wr_stat(9, 3'b010);
        cmp_chk(9, m_tag[9], 1'b0, "R9 dirty only, dedicated");
        cmp_chk(9, m_tag[9], 1'b1, "R9 dirty only, generic");
        wr_stat(9, 3'b011);
        cmp_chk(9, m_tag[9], 1'b0, "R9 dirty plus valid, dedicated");

        // R4: no match while a tag write is requested
        @(negedge clk); idle(); generic_mode = 1'b1; addr = 4; tag_i = m_tag[4]; we_tag_n = 1'b0;
        #1;
        chk(match_o === 1'b0, "R4 no match during write", 32'(match_o), 0);
        @(posedge clk);

        // R2: overwrite one entry and probe with the new tag
        wr_tag(cpu_addr(7, 3));
        cmp_chk(7, m_tag[7], 1'b1, "R2 new tag hits");
        read_chk(6, "R2 neighbour untouched", "R5 neighbour status");

        // R1/R7: deselect via each chip select, write attempts ignored
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); idle();
            if (k == 0) cs_n = 1'b1; else cs = 1'b0;
            addr = 3; tag_i = ~m_tag[3]; stat_i = ~m_stat[3];
            we_tag_n = 1'b0; we_stat_n = 1'b0; oe_stat_n = 1'b0;
            #1;
            chk(stat_oe === 1'b0, "R1 R7 stat_oe low deselected", 32'(stat_oe), 0);
            chk(match_oe === 1'b0, "R1 R7 match_oe low deselected", 32'(match_oe), 0);
            @(posedge clk);
            @(negedge clk); we_tag_n = 1'b1; we_stat_n = 1'b1; oe_tag_n = 1'b0; tag_i = m_tag[3];
            #1;
            chk(tag_oe === 1'b0, "R1 R7 tag_oe low deselected", 32'(tag_oe), 0);
            oe_tag_n = 1'b1; #1;
            chk(match_o === 1'b0, "R7 match low deselected", 32'(match_o), 0);
            read_chk(3, "R7 tag unchanged by deselected write", "R7 status unchanged by deselected write");
        end

        // R6/R10: reset with a simultaneous status write; tags remain
        @(negedge clk); idle(); rst = 1'b1; addr = 2; stat_i = 3'b111; we_stat_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst = 1'b0; idle();
        for (int i = 0; i < DEPTH; i++) m_stat[i] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            read_chk(i, "R10 tag kept through reset", "R6 status cleared again");
            cmp_chk(i, m_tag[i], 1'b0, "R8 miss after reset");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule